// File: doc/BRIEF.md
# Phased Instruction Region Locator

This block finds the operation regions inside one variable-length instruction, so that three per-phase operation decoders can start work before the whole instruction has been interpreted. Each instruction opens with a 16-bit header in its first two bytes. The header gives the instruction's length in bytes and an operation count for each of three phases. Phase 0 operations sit directly after the header. Phase 2 operations follow phase 0. Phase 1 operations are packed against the end of the instruction. Operation widths are fixed per phase, so region edges fall on arbitrary bit positions. Whatever is left between the end of phase 2 and the start of phase 1 may carry a small delay count. That count is meant for the issue stall counter of the opposite instruction stream.

The block is a two-stage pipeline fed with a byte window holding the instruction at bit 0 (byte k in bits 8k+7..8k) and a valid flag. One cycle after a valid window, it presents the largest possible phase 0 region as a speculative slice, before the header has been examined. One cycle later it presents the parsed layout. This includes the start bits of the phase 2 and phase 1 regions, a cancel mask for each phase's operation slots, the byte offset of the next instruction, a malformed flag, and the delay count with its strobe. A new window may arrive every cycle.

Top module: `phase_region_locator`

## Requirements
- R1: After a synchronous reset with no valid input, `spec_vld`, `out_vld` and `dly_vld` are all low.
- R2: One cycle after `in_vld` is sampled high, `spec_vld` is high and `spec_bits` equals window bits 16 to 85 (seven 10-bit phase 0 slots), whatever the header holds.
- R3: Header fields: bits [5:0] are the length L in bytes, bits [8:6] the phase 0 count C0, bits [11:9] the phase 1 count C1, and bits [14:12] the phase 2 count C2. Two cycles after the input, `out_vld` is high, `p2_start` = 16 + 10*C0 and `p1_start` = 8*L − 12*C1.
- R4: For each phase p, bit i of `pX_cancel` is 1 exactly when i >= Cp (slots 0 to 6).
- R5: On a well-formed instruction whose gap from bit 16+10*C0+14*C2 up to `p1_start` is at least 4 bits wide, `dly` equals the 4 window bits starting at the gap's first bit, with the least significant bit at the lowest position.
- R6: When the gap is 0 to 3 bits wide, `dly` is 0, whatever those bits hold.
- R7: When 16+10*C0+12*C1+14*C2 > 8*L, `malformed` is high, all three cancel masks are all ones, `dly` is 0 and `dly_vld` is low.
- R8: `dly_vld` is high for exactly one cycle per well-formed instruction, in the same cycle as its `out_vld`.
- R9: Windows presented on consecutive cycles each produce their speculative slice and their parsed results on consecutive cycles, in order.
- R10: Header bit 15 has no effect on any output.
- R11: `next_off` equals L, the byte offset at which the following instruction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Window holds an instruction at bit 0 |
| in_win | input | 512 | Byte window, byte k at bits 8k+7..8k |
| spec_vld | output | 1 | Speculative phase 0 slice valid |
| spec_bits | output | 70 | Maximum-size phase 0 region |
| out_vld | output | 1 | Parsed layout valid |
| next_off | output | 6 | Byte offset of the next instruction |
| p2_start | output | 10 | First bit of the phase 2 region |
| p1_start | output | 10 | First bit of the phase 1 region |
| p0_cancel | output | 7 | Phase 0 slots to discard |
| p1_cancel | output | 7 | Phase 1 slots to discard |
| p2_cancel | output | 7 | Phase 2 slots to discard |
| malformed | output | 1 | Counts overflow the stated length |
| dly_vld | output | 1 | Delay strobe for the opposite stream |
| dly | output | 4 | Delay count |

## Verification
The hardest cases to reach are at the edges of the alignment gap. These are an instruction whose regions leave a gap of exactly four bits, one whose gap is one to three bits wide, and one whose counts exceed the stated length by a single byte. Random headers almost never land on these edges. The stimulus therefore picks count and length pairs by arithmetic so that the gap is exactly 4, 2 and 0 bits, and so that one length is valid while the length one byte shorter is malformed. It fills the short gaps with ones so that a missing guard would show up as a non-zero delay. Back-to-back windows with different layouts check that the speculative slice of one instruction and the parsed layout of the one before it appear in the same cycle without mixing.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int HDR_W   = 16;
  localparam int LEN_W   = 6;
  localparam int CNT_W   = 3;
  localparam int MAX_OPS = (1 << CNT_W) - 1;
  localparam int OP_W0   = 10;
  localparam int OP_W1   = 12;
  localparam int OP_W2   = 14;
  localparam int DLY_W   = 4;
  localparam int POS_W   = 10;
  localparam int NPHASE  = 3;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [CNT_W-1:0] c0;
    logic [CNT_W-1:0] c1;
    logic [CNT_W-1:0] c2;
    logic [POS_W-1:0] p2_start;
    logic [POS_W-1:0] p2_end;
    logic [POS_W-1:0] p1_start;
    logic             malformed;
    logic             gap_ok;
  } region_t;
endpackage

// File: rtl/pir_spec_stage.sv
module pir_spec_stage #(
  parameter int WIN_W  = 512,
  parameter int P0_OFF = 16,
  parameter int P0_W   = 70
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [WIN_W-1:0] in_win,
  output logic             s0_vld,
  output logic [WIN_W-1:0] s0_win,
  output logic [P0_W-1:0]  spec_bits
);
  always_ff @(posedge clk) begin
    if (rst) s0_vld <= 1'b0;
    else     s0_vld <= in_vld;
    if (in_vld) s0_win <= in_win;
  end

  // phase 0 starts at a fixed offset, so its widest slice needs no header
  assign spec_bits = s0_win[P0_OFF +: P0_W];
endmodule

// File: rtl/pir_region_calc.sv
module pir_region_calc
  import pir_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  output region_t          r
);
  logic [POS_W-1:0] end_pos, b0, b1, b2, need;

  always_comb begin
    r.len = hdr[LEN_W-1:0];
    r.c0  = hdr[LEN_W +: CNT_W];
    r.c1  = hdr[LEN_W + CNT_W +: CNT_W];
    r.c2  = hdr[LEN_W + 2*CNT_W +: CNT_W];
    end_pos = POS_W'(r.len) << 3;
    b0 = POS_W'(r.c0) * POS_W'(OP_W0);
    b1 = POS_W'(r.c1) * POS_W'(OP_W1);
    b2 = POS_W'(r.c2) * POS_W'(OP_W2);
    r.p2_start  = POS_W'(HDR_W) + b0;
    r.p2_end    = r.p2_start + b2;
    need        = r.p2_end + b1;
    r.malformed = need > end_pos;
    r.p1_start  = end_pos - b1;
    r.gap_ok    = !r.malformed && (r.p1_start >= r.p2_end + POS_W'(DLY_W));
  end
endmodule

// File: rtl/pir_slot_mask.sv
module pir_slot_mask #(
  parameter int CNT_W   = 3,
  parameter int MAX_OPS = 7
) (
  input  logic [CNT_W-1:0]   cnt,
  input  logic               kill,
  output logic [MAX_OPS-1:0] cancel
);
  for (genvar i = 0; i < MAX_OPS; i++) begin : g_slot
    assign cancel[i] = kill || (CNT_W'(i) >= cnt);
  end
endmodule

// File: rtl/pir_gap_extract.sv
module pir_gap_extract #(
  parameter int WIN_W = 512,
  parameter int POS_W = 10,
  parameter int DLY_W = 4
) (
  input  logic [WIN_W-1:0] win,
  input  logic [POS_W-1:0] pos,
  input  logic             gap_ok,
  output logic [DLY_W-1:0] dly
);
  logic [WIN_W-1:0] shifted;
  always_comb begin
    shifted = win >> pos;
    dly = gap_ok ? shifted[DLY_W-1:0] : '0;
  end
endmodule

// File: rtl/phase_region_locator.sv
module phase_region_locator
  import pir_pkg::*;
#(
  parameter int WIN_BYTES = 64,
  localparam int WIN_W    = WIN_BYTES * 8,
  localparam int P0_W     = MAX_OPS * OP_W0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [WIN_W-1:0]   in_win,
  output logic               spec_vld,
  output logic [P0_W-1:0]    spec_bits,
  output logic               out_vld,
  output logic [LEN_W-1:0]   next_off,
  output logic [POS_W-1:0]   p2_start,
  output logic [POS_W-1:0]   p1_start,
  output logic [MAX_OPS-1:0] p0_cancel,
  output logic [MAX_OPS-1:0] p1_cancel,
  output logic [MAX_OPS-1:0] p2_cancel,
  output logic               malformed,
  output logic               dly_vld,
  output logic [DLY_W-1:0]   dly
);
  logic [WIN_W-1:0]   s0_win;
  region_t            rg;
  logic [CNT_W-1:0]   cnt_a  [NPHASE];
  logic [MAX_OPS-1:0] mask_a [NPHASE];
  logic [DLY_W-1:0]   dly_c;

  pir_spec_stage #(.WIN_W(WIN_W), .P0_OFF(HDR_W), .P0_W(P0_W)) u_spec (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_win(in_win),
    .s0_vld(spec_vld), .s0_win(s0_win), .spec_bits(spec_bits));

  pir_region_calc u_calc (.hdr(s0_win[HDR_W-1:0]), .r(rg));

  assign cnt_a[0] = rg.c0;
  assign cnt_a[1] = rg.c1;
  assign cnt_a[2] = rg.c2;

  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    pir_slot_mask #(.CNT_W(CNT_W), .MAX_OPS(MAX_OPS)) u_mask (
      .cnt(cnt_a[p]), .kill(rg.malformed), .cancel(mask_a[p]));
  end

  pir_gap_extract #(.WIN_W(WIN_W), .POS_W(POS_W), .DLY_W(DLY_W)) u_gap (
    .win(s0_win), .pos(rg.p2_end), .gap_ok(rg.gap_ok), .dly(dly_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      dly_vld   <= 1'b0;
      next_off  <= '0;
      p2_start  <= '0;
      p1_start  <= '0;
      p0_cancel <= '1;
      p1_cancel <= '1;
      p2_cancel <= '1;
      malformed <= 1'b0;
      dly       <= '0;
    end else begin
      out_vld   <= spec_vld;
      dly_vld   <= spec_vld && !rg.malformed;
      next_off  <= rg.len;
      p2_start  <= rg.p2_start;
      p1_start  <= rg.p1_start;
      p0_cancel <= mask_a[0];
      p1_cancel <= mask_a[1];
      p2_cancel <= mask_a[2];
      malformed <= rg.malformed;
      dly       <= dly_c;
    end
  end

  assert_spec_follows_input_R2: assert property (@(posedge clk) disable iff (rst)
    spec_vld |-> $past(in_vld));
  assert_region_order_R3: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !malformed) |-> (p2_start <= p1_start));
  assert_mask_shape_R4: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ((((~p0_cancel) + 1'b1) & (~p0_cancel)) == '0));
  assert_malformed_kill_R7: assert property (@(posedge clk) disable iff (rst)
    (out_vld && malformed) |-> (&p0_cancel && &p1_cancel && &p2_cancel && dly == '0));
  assert_dly_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    dly_vld |-> (out_vld && !malformed));
  assert_strobe_once_R9: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(spec_vld));
endmodule

// File: tb/test_phase_region_locator.sv
module test_phase_region_locator;
  localparam int WIN_W = 512;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_vld = 1'b0;
  logic [WIN_W-1:0] in_win = '0;
  logic             spec_vld, out_vld, malformed, dly_vld;
  logic [69:0]      spec_bits;
  logic [5:0]       next_off;
  logic [9:0]       p2_start, p1_start;
  logic [6:0]       p0_cancel, p1_cancel, p2_cancel;
  logic [3:0]       dly;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  phase_region_locator i_phase_region_locator (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_win(in_win),
    .spec_vld(spec_vld), .spec_bits(spec_bits), .out_vld(out_vld),
    .next_off(next_off), .p2_start(p2_start), .p1_start(p1_start),
    .p0_cancel(p0_cancel), .p1_cancel(p1_cancel), .p2_cancel(p2_cancel),
    .malformed(malformed), .dly_vld(dly_vld), .dly(dly));

  task automatic cmp(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WIN_W-1:0] mk(int len, int c0, int c1, int c2,
                                           int rsv, int dl, logic [31:0] seed);
    logic [WIN_W-1:0] w;
    int p2e, p1s, need;
    for (int i = 0; i < WIN_W/32; i++) w[i*32 +: 32] = seed ^ (i * 32'h9E3779B9);
    w[5:0]   = 6'(len);
    w[8:6]   = 3'(c0);
    w[11:9]  = 3'(c1);
    w[14:12] = 3'(c2);
    w[15]    = 1'(rsv);
    p2e  = 16 + 10*c0 + 14*c2;
    p1s  = 8*len - 12*c1;
    need = p2e + 12*c1;
    if (need <= 8*len && p1s - p2e >= 4) w[p2e +: 4] = 4'(dl);
    else if (need <= 8*len)
      for (int b = p2e; b < p1s; b++) w[b] = 1'b1;
    return w;
  endfunction

  function automatic logic [6:0] cmask(int c, bit kill);
    return kill ? 7'h7f : (7'h7f << c) & 7'h7f;
  endfunction

  task automatic check_parse(string req, int len, int c0, int c1, int c2, int dl);
    bit bad;
    bit wide;
    bad  = (16 + 10*c0 + 12*c1 + 14*c2) > 8*len;
    wide = !bad && ((8*len - 12*c1) - (16 + 10*c0 + 14*c2) >= 4);
    cmp(req, "out_vld", 128'(out_vld), 128'(1));
    cmp("R11", "next_off", 128'(next_off), 128'(len));
    cmp("R7", "malformed", 128'(malformed), 128'(bad));
    if (!bad) begin
      cmp("R3", "p2_start", 128'(p2_start), 128'(16 + 10*c0));
      cmp("R3", "p1_start", 128'(p1_start), 128'(8*len - 12*c1));
    end
    cmp("R4", "p0_cancel", 128'(p0_cancel), 128'(cmask(c0, bad)));
    cmp("R4", "p1_cancel", 128'(p1_cancel), 128'(cmask(c1, bad)));
    cmp("R4", "p2_cancel", 128'(p2_cancel), 128'(cmask(c2, bad)));
    cmp("R8", "dly_vld", 128'(dly_vld), 128'(!bad));
    cmp(wide ? "R5" : "R6", "dly", 128'(dly), 128'(wide ? dl : 0));
  endtask

  task automatic run_one(string req, int len, int c0, int c1, int c2,
                         int rsv, int dl, logic [31:0] seed);
    logic [WIN_W-1:0] w;
    w = mk(len, c0, c1, c2, rsv, dl, seed);
    @(negedge clk); in_vld = 1'b1; in_win = w;
    @(negedge clk); in_vld = 1'b0; in_win = '0;
    cmp("R2", "spec_vld", 128'(spec_vld), 128'(1));
    cmp("R2", "spec_bits", 128'(spec_bits), 128'(w[16 +: 70]));
    @(negedge clk);
    check_parse(req, len, c0, c1, c2, dl);
    @(negedge clk);
    cmp("R8", "out_vld low after", 128'(out_vld), 128'(0));
    cmp("R8", "dly_vld low after", 128'(dly_vld), 128'(0));
  endtask

  task automatic test_reset;
    cmp("R1", "spec_vld", 128'(spec_vld), 128'(0));
    cmp("R1", "out_vld", 128'(out_vld), 128'(0));
    cmp("R1", "dly_vld", 128'(dly_vld), 128'(0));
  endtask

  task automatic test_reserved_r10;
    logic [69:0] sb;
    run_one("R10", 20, 3, 2, 2, 0, 9, 32'h1234_5678);
    run_one("R10", 20, 3, 2, 2, 1, 9, 32'h1234_5678);
    sb = spec_bits;
    cmp("R10", "region unchanged", 128'(p1_start), 128'(8*20 - 24));
  endtask

  task automatic test_back_to_back_r9;
    logic [WIN_W-1:0] wa, wb, wc;
    wa = mk(30, 4, 3, 2, 0, 5, 32'hCAFE_0001);
    wb = mk(12, 2, 1, 1, 0, 12, 32'hBEEF_0002);
    wc = mk(3, 1, 1, 1, 0, 0, 32'h0BAD_0003);
    @(negedge clk); in_vld = 1'b1; in_win = wa;
    @(negedge clk); in_win = wb;
    cmp("R9", "spec A", 128'(spec_bits), 128'(wa[16 +: 70]));
    @(negedge clk); in_win = wc;
    cmp("R9", "spec B", 128'(spec_bits), 128'(wb[16 +: 70]));
    check_parse("R9", 30, 4, 3, 2, 5);
    @(negedge clk); in_vld = 1'b0; in_win = '0;
    cmp("R9", "spec C", 128'(spec_bits), 128'(wc[16 +: 70]));
    check_parse("R9", 12, 2, 1, 1, 12);
    @(negedge clk);
    check_parse("R9", 3, 1, 1, 1, 0);
    @(negedge clk);
    cmp("R9", "out_vld drained", 128'(out_vld), 128'(0));
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_one("R3", 20, 3, 2, 2, 0, 9, 32'hA5C3_96E1);     // wide gap, delay 9
    run_one("R5", 7, 1, 1, 1, 0, 13, 32'h5555_0F0F);     // gap exactly 4 bits
    run_one("R6", 5, 1, 1, 0, 0, 0, 32'h0000_0000);      // gap 2 bits, filled with ones
    run_one("R6", 2, 0, 0, 0, 0, 0, 32'hFFFF_FFFF);      // header only, gap 0
    run_one("R3", 34, 7, 7, 7, 0, 6, 32'h3C3C_A5A5);     // all slots used, fits
    run_one("R7", 33, 7, 7, 7, 0, 6, 32'h3C3C_A5A5);     // one byte short
    run_one("R7", 1, 0, 0, 0, 0, 0, 32'h7777_1111);      // shorter than header
    run_one("R4", 63, 0, 5, 6, 0, 15, 32'h0123_4567);
    test_reserved_r10();
    test_back_to_back_r9();
    finish_run();
  end
endmodule